// File: doc/BRIEF.md
# Table-Driven Bus Waveform Sequencer

This block drives the strobes of an external byte-wide device, such as a NAND flash part, from a small table of microcode words. Each word sets three control outputs for one clock. It can also hold the sequencer until the two ready inputs reach a chosen pattern, or use that pattern to jump elsewhere in the table. The same word can pulse a FIFO-advance strobe and an address-increment strobe. One pass through the table, ending at a word marked as the final one, makes up one transaction. The engine repeats the pass until a 32-bit transaction count runs out.

While the engine is idle, a host writes the 16-entry table, the transaction count and the idle value of the control outputs, then pulses start. The engine runs with no further help from the host. When a word would advance the FIFO while the FIFO has no data (transfers toward the device) or no space (transfers from the device), the engine holds that word. The remaining count can be read at all times. An abort input returns the engine to idle on the next clock.

Top module: `bus_wave_engine`

## Requirements
- R1: After reset, busy, done, both strobes, the control outputs, the vector pointer and the transaction count are all zero.
- R2: A table word is 15 bits: ctl[2:0], ready mask [4:3], ready polarity [6:5], branch flag [7], branch target [11:8], FIFO advance [12], address increment [13], final word [14]. While running, the control outputs show the current word's ctl field, and a word that is not held lasts exactly one clock.
- R3: A word with branch flag 0 and a nonzero mask is held until every masked ready bit equals its polarity bit.
- R4: A word with branch flag 1 never waits. If the masked ready bits match, the next word is the branch target; otherwise it is the following word.
- R5: The FIFO-advance and address-increment outputs pulse high only in the clock in which a word carrying that bit completes. They are never high while idle.
- R6: When the final word completes, the count drops by one. If the count does not reach zero, execution restarts at word 0.
- R7: When the count reaches zero, done rises, busy falls and the control outputs return to the idle value. Done is cleared by start and by abort.
- R8: With direction 1 (toward the device), a word with FIFO advance set is held while fifo_empty is high. With direction 0, such a word is held while fifo_full is high, and fifo_empty has no effect. A held word gives no strobe and leaves the count unchanged.
- R9: Abort sends the engine to idle on the next clock with busy and done low. The remaining count is kept.
- R10: Writes to the count and to the table are ignored while busy. Start with a count of zero sets done without running.
- R11: The idle value of the control outputs is a register written through idle_we. It appears on the control outputs whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_we | input | 1 | Table word write strobe (idle only) |
| vec_addr | input | 4 | Table word index |
| vec_wdata | input | 15 | Table word |
| cnt_we | input | 1 | Transaction count write strobe (idle only) |
| cnt_wdata | input | 32 | Transaction count value |
| idle_we | input | 1 | Idle control value write strobe |
| idle_wdata | input | 3 | Idle control value |
| start | input | 1 | Begin executing at word 0 |
| abort | input | 1 | Return to idle at once |
| dir_to_dev | input | 1 | 1: FIFO to device, 0: device to FIFO |
| fifo_empty | input | 1 | FIFO holds no data |
| fifo_full | input | 1 | FIFO has no space |
| rdy | input | 2 | Ready inputs from the device |
| ctl | output | 3 | Control outputs to the device |
| fifo_adv | output | 1 | FIFO advance strobe |
| addr_inc | output | 1 | Address increment strobe |
| busy | output | 1 | Engine running |
| done | output | 1 | Count exhausted |
| txn_count | output | 32 | Remaining transactions |
| vec_ptr | output | 4 | Index of the current word |

## Verification
The checker watches five things on every clock. There are no strobes while idle. No FIFO advance is issued against an empty or full FIFO. Abort lands in idle. The count changes by at most one per clock while running and stays fixed in idle unless written. Done rises only when the count is zero and busy is low. Other behaviour depends on the table contents, so only the bench scenarios can show it. That covers the exact order of control values and strobes, waiting on ready polarity, taking and skipping branches, restarting at word 0, and host writes being ignored while the engine runs.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int CTL_W     = 3;
  localparam int RDY_W     = 2;
  localparam int VEC_AW    = 4;
  localparam int VEC_DEPTH = 1 << VEC_AW;

  typedef struct packed {
    logic              last;
    logic              inc;
    logic              adv;
    logic [VEC_AW-1:0] tgt;
    logic              br;
    logic [RDY_W-1:0]  pol;
    logic [RDY_W-1:0]  mask;
    logic [CTL_W-1:0]  ctl;
  } vec_t;

  localparam int VEC_W = $bits(vec_t);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;
endpackage

// File: rtl/wseq_rst_sync.sv
module wseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wseq_vec_mem.sv
module wseq_vec_mem
  import wseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [VEC_AW-1:0] waddr,
  input  vec_t              wdata,
  input  logic [VEC_AW-1:0] raddr,
  output vec_t              rdata
);
  vec_t ent_arr [VEC_DEPTH];

  for (genvar g = 0; g < VEC_DEPTH; g++) begin : g_ent
    logic wr_en;
    vec_t ent_q;
    assign wr_en = we && (waddr == VEC_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ent_q <= '0;
      else if (wr_en) ent_q <= wdata;
    end
    assign ent_arr[g] = ent_q;
  end

  assign rdata = ent_arr[raddr];
endmodule

// File: rtl/wseq_step.sv
module wseq_step
  import wseq_pkg::*;
(
  input  vec_t              cur,
  input  logic [VEC_AW-1:0] idx,
  input  logic [RDY_W-1:0]  rdy,
  input  logic              dir_to_dev,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  output logic              fire,
  output logic [VEC_AW-1:0] nxt
);
  logic [RDY_W-1:0] bit_ok;
  logic             rdy_match;
  logic             fifo_block;

  for (genvar b = 0; b < RDY_W; b++) begin : g_rdy
    assign bit_ok[b] = !cur.mask[b] || (rdy[b] == cur.pol[b]);
  end

  always_comb begin
    rdy_match  = &bit_ok;
    fifo_block = cur.adv && (dir_to_dev ? fifo_empty : fifo_full);
    fire       = !fifo_block && (cur.br || rdy_match);
    nxt        = (cur.br && rdy_match) ? cur.tgt : idx + 1'b1;
  end
endmodule

// File: rtl/wseq_txn_cnt.sv
module wseq_txn_cnt #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          dec_en,
  output logic [CW-1:0] count,
  output logic          is_zero,
  output logic          is_one
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_en || dec_en;
    cnt_d  = load_en ? load_val : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == CW'(1));
endmodule

// File: rtl/wseq_ctrl.sv
module wseq_ctrl
  import wseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              fire,
  input  logic              last,
  input  logic [VEC_AW-1:0] nxt,
  input  logic              cnt_zero,
  input  logic              cnt_one,
  input  logic              idle_we,
  input  logic [CTL_W-1:0]  idle_wdata,
  output logic              busy,
  output logic              done,
  output logic [VEC_AW-1:0] idx,
  output logic [CTL_W-1:0]  idle_ctl,
  output logic              go,
  output logic              dec_en
);
  st_e               state_q, state_d;
  logic [VEC_AW-1:0] idx_q, idx_d;
  logic              done_q, done_d;
  logic [CTL_W-1:0]  idle_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = done_q;
    unique case (state_q)
      ST_IDLE: begin
        if (abort) begin
          done_d = 1'b0;
        end else if (start) begin
          if (cnt_zero) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_RUN;
            idx_d   = '0;
            done_d  = 1'b0;
          end
        end
      end
      ST_RUN: begin
        if (abort) begin
          state_d = ST_IDLE;
          idx_d   = '0;
        end else if (fire) begin
          if (last) begin
            idx_d = '0;
            if (cnt_one) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end else begin
            idx_d = nxt;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idle_q <= '0;
    else if (idle_we) idle_q <= idle_wdata;
  end

  assign busy     = (state_q == ST_RUN);
  assign done     = done_q;
  assign idx      = idx_q;
  assign idle_ctl = idle_q;
  assign go       = busy && fire && !abort;
  assign dec_en   = go && last;
endmodule

// File: rtl/bus_wave_engine.sv
module bus_wave_engine
  import wseq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_we,
  input  logic [VEC_AW-1:0] vec_addr,
  input  logic [VEC_W-1:0]  vec_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              idle_we,
  input  logic [CTL_W-1:0]  idle_wdata,
  input  logic              start,
  input  logic              abort,
  input  logic              dir_to_dev,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic [RDY_W-1:0]  rdy,
  output logic [CTL_W-1:0]  ctl,
  output logic              fifo_adv,
  output logic              addr_inc,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  txn_count,
  output logic [VEC_AW-1:0] vec_ptr
);
  logic              rst_n_i;
  vec_t              cur;
  logic              fire;
  logic [VEC_AW-1:0] nxt;
  logic              cnt_zero, cnt_one;
  logic              go, dec_en;
  logic [CTL_W-1:0]  idle_ctl;
  logic              tbl_we, cnt_load;

  assign tbl_we   = vec_we && !busy;
  assign cnt_load = cnt_we && !busy;

  wseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  wseq_vec_mem u_mem (
    .clk   (clk),
    .rst_n (rst_n_i),
    .we    (tbl_we),
    .waddr (vec_addr),
    .wdata (vec_t'(vec_wdata)),
    .raddr (vec_ptr),
    .rdata (cur)
  );

  wseq_step u_step (
    .cur        (cur),
    .idx        (vec_ptr),
    .rdy        (rdy),
    .dir_to_dev (dir_to_dev),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fire       (fire),
    .nxt        (nxt)
  );

  wseq_txn_cnt #(.CW(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load_en  (cnt_load),
    .load_val (cnt_wdata),
    .dec_en   (dec_en),
    .count    (txn_count),
    .is_zero  (cnt_zero),
    .is_one   (cnt_one)
  );

  wseq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start      (start),
    .abort      (abort),
    .fire       (fire),
    .last       (cur.last),
    .nxt        (nxt),
    .cnt_zero   (cnt_zero),
    .cnt_one    (cnt_one),
    .idle_we    (idle_we),
    .idle_wdata (idle_wdata),
    .busy       (busy),
    .done       (done),
    .idx        (vec_ptr),
    .idle_ctl   (idle_ctl),
    .go         (go),
    .dec_en     (dec_en)
  );

  assign ctl      = busy ? cur.ctl : idle_ctl;
  assign fifo_adv = go && cur.adv;
  assign addr_inc = go && cur.inc;
endmodule

// File: rtl/wseq_chk.sv
module wseq_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             abort,
  input logic             cnt_we,
  input logic             fifo_adv,
  input logic             addr_inc,
  input logic             dir_to_dev,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic [CNT_W-1:0] txn_count
);
  // R5: strobes stay low while the engine is idle
  p_no_strobe_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fifo_adv && !addr_inc));

  // R8: no advance toward the device while the FIFO is empty
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dir_to_dev && fifo_empty) |-> !fifo_adv);

  // R8: no advance from the device while the FIFO is full
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dir_to_dev && fifo_full) |-> !fifo_adv);

  // R9: abort lands in idle with done low
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done));

  // R6: the count moves by at most one per clock while running
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((txn_count == $past(txn_count)) || (txn_count == $past(txn_count) - 1)));

  // R7: done rises only with the count exhausted and the engine idle
  p_done_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (txn_count == '0 && !busy));

  // R7: done and busy never overlap
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: in idle the count changes only through a host write
  p_idle_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cnt_we) |=> $stable(txn_count));
endmodule

bind bus_wave_engine wseq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .abort      (abort),
  .cnt_we     (cnt_we),
  .fifo_adv   (fifo_adv),
  .addr_inc   (addr_inc),
  .dir_to_dev (dir_to_dev),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .txn_count  (txn_count)
);

// File: tb/bus_wave_engine_tb.sv
module bus_wave_engine_tb;
  localparam int WATCHDOG = 100000;

  logic        clk;
  logic        rst_n;
  logic        vec_we;
  logic [3:0]  vec_addr;
  logic [14:0] vec_wdata;
  logic        cnt_we;
  logic [31:0] cnt_wdata;
  logic        idle_we;
  logic [2:0]  idle_wdata;
  logic        start, abort, dir_to_dev, fifo_empty, fifo_full;
  logic [1:0]  rdy;
  logic [2:0]  ctl;
  logic        fifo_adv, addr_inc, busy, done;
  logic [31:0] txn_count;
  logic [3:0]  vec_ptr;

  bus_wave_engine u_dut (
    .clk(clk), .rst_n(rst_n), .vec_we(vec_we), .vec_addr(vec_addr),
    .vec_wdata(vec_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .idle_we(idle_we), .idle_wdata(idle_wdata), .start(start), .abort(abort),
    .dir_to_dev(dir_to_dev), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .rdy(rdy), .ctl(ctl), .fifo_adv(fifo_adv), .addr_inc(addr_inc),
    .busy(busy), .done(done), .txn_count(txn_count), .vec_ptr(vec_ptr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0] ctl;
    logic       adv;
    logic       inc;
    int         req;
  } item_t;
  item_t sb_q[$];
  bit    mon_on = 0;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
      report();
    end
  end

  // Scoreboard monitor: one expected item per running clock
  always @(negedge clk) begin
    if (mon_on && busy) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R2 extra running cycle: actual ctl=%0d expected=idle", ctl);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (ctl !== it.ctl || fifo_adv !== it.adv || addr_inc !== it.inc) begin
          errors++;
          $display("FAIL R%0d step: actual ctl=%0d adv=%0b inc=%0b expected ctl=%0d adv=%0b inc=%0b",
                   it.req, ctl, fifo_adv, addr_inc, it.ctl, it.adv, it.inc);
        end
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [14:0] mkvec(logic [2:0] c, logic [1:0] m, logic [1:0] p,
                                        logic b, logic [3:0] t, logic a, logic i, logic l);
    return {l, i, a, t, b, p, m, c};
  endfunction

  task automatic load_vec(logic [3:0] a, logic [14:0] w);
    vec_we = 1'b1; vec_addr = a; vec_wdata = w;
    tick();
    vec_we = 1'b0;
  endtask

  task automatic set_count(logic [31:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    tick();
    cnt_we = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic push(logic [2:0] c, logic a, logic i, int req);
    item_t it;
    it.ctl = c; it.adv = a; it.inc = i; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic end_run(string req);
    wait_idle();
    mon_on = 0;
    chk({req, " queue drained"}, 64'(sb_q.size()), 64'd0);
    sb_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; vec_we = 0; vec_addr = 0; vec_wdata = 0; cnt_we = 0; cnt_wdata = 0;
    idle_we = 0; idle_wdata = 0; start = 0; abort = 0; dir_to_dev = 1;
    fifo_empty = 0; fifo_full = 0; rdy = 2'b00;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 ctl", 64'(ctl), 64'd0);
    chk("R1 strobes", 64'({fifo_adv, addr_inc}), 64'd0);
    chk("R1 count", 64'(txn_count), 64'd0);
    chk("R1 ptr", 64'(vec_ptr), 64'd0);

    // R11: idle value register drives the outputs in idle
    idle_we = 1'b1; idle_wdata = 3'd5;
    tick();
    idle_we = 1'b0;
    chk("R11 idle ctl", 64'(ctl), 64'd5);

    // R2 R5 R6 R7: three words, two transactions
    load_vec(0, mkvec(3'd1, 2'b00, 2'b00, 0, 4'd0, 1, 0, 0));
    load_vec(1, mkvec(3'd2, 2'b00, 2'b00, 0, 4'd0, 0, 1, 0));
    load_vec(2, mkvec(3'd4, 2'b00, 2'b00, 0, 4'd0, 0, 0, 1));
    set_count(32'd2);
    for (int t = 0; t < 2; t++) begin
      push(3'd1, 1, 0, 5);  // R5 advance strobe
      push(3'd2, 0, 1, 5);  // R5 address strobe
      push(3'd4, 0, 0, 6);  // R6 final word, restart at 0
    end
    mon_on = 1;
    pulse_start();
    end_run("R2");
    chk("R7 done after count", 64'(done), 64'd1);
    chk("R6 count zero", 64'(txn_count), 64'd0);
    chk("R7 ctl back to idle value", 64'(ctl), 64'd5);

    // R3: hold until rdy[0] is high
    load_vec(0, mkvec(3'd3, 2'b01, 2'b01, 0, 4'd0, 0, 0, 1));
    set_count(32'd1);
    rdy = 2'b00;
    for (int k = 0; k < 6; k++) push(3'd3, 0, 0, 3);  // R3 wait then complete
    mon_on = 1;
    pulse_start();
    chk("R7 done cleared by start", 64'(done), 64'd0);
    repeat (5) tick();
    rdy = 2'b01;
    end_run("R3");
    chk("R3 done", 64'(done), 64'd1);
    rdy = 2'b00;

    // R4: branch on rdy[1] low to word 2, else fall through
    load_vec(0, mkvec(3'd1, 2'b10, 2'b00, 1, 4'd2, 0, 0, 0));
    load_vec(1, mkvec(3'd5, 2'b00, 2'b00, 0, 4'd0, 0, 0, 1));
    load_vec(2, mkvec(3'd6, 2'b00, 2'b00, 0, 4'd0, 0, 1, 1));
    set_count(32'd1);
    push(3'd1, 0, 0, 4);
    push(3'd6, 0, 1, 4);  // R4 taken branch
    mon_on = 1;
    pulse_start();
    end_run("R4 taken");
    rdy = 2'b10;
    set_count(32'd1);
    push(3'd1, 0, 0, 4);
    push(3'd5, 0, 0, 4);  // R4 branch not taken, no wait
    mon_on = 1;
    pulse_start();
    end_run("R4 not taken");
    rdy = 2'b00;

    // R8: throttling toward the device (empty) and from it (full)
    load_vec(0, mkvec(3'd7, 2'b00, 2'b00, 0, 4'd0, 1, 0, 1));
    for (int d = 1; d >= 0; d--) begin
      dir_to_dev = d[0];
      fifo_empty = 1'b1;
      fifo_full  = (d == 0);
      set_count(32'd1);
      for (int k = 0; k < 4; k++) push(3'd7, 0, 0, 8);  // R8 held, no strobe
      push(3'd7, 1, 0, 8);
      mon_on = 1;
      pulse_start();
      repeat (4) tick();
      chk("R8 count held while stalled", 64'(txn_count), 64'd1);
      fifo_empty = 1'b0;
      fifo_full  = 1'b0;
      end_run("R8");
    end
    dir_to_dev = 1'b1;

    // R9 R10: abort mid-run, host writes ignored while busy
    load_vec(0, mkvec(3'd2, 2'b00, 2'b00, 0, 4'd0, 1, 0, 0));
    load_vec(1, mkvec(3'd3, 2'b00, 2'b00, 0, 4'd0, 0, 0, 1));
    set_count(32'd100);
    pulse_start();
    repeat (4) tick();
    cnt_we = 1'b1; cnt_wdata = 32'd7;
    vec_we = 1'b1; vec_addr = 4'd1; vec_wdata = mkvec(3'd6, 2'b00, 2'b00, 0, 4'd0, 0, 0, 1);
    tick();
    cnt_we = 1'b0; vec_we = 1'b0;
    repeat (5) tick();
    abort = 1'b1;
    tick();
    abort = 1'b0;
    @(negedge clk);
    chk("R9 busy after abort", 64'(busy), 64'd0);
    chk("R9 done after abort", 64'(done), 64'd0);
    chk("R10 count kept, write ignored", 64'(txn_count), 64'd95);
    chk("R9 ctl idle value", 64'(ctl), 64'd5);
    set_count(32'd1);
    push(3'd2, 1, 0, 10);
    push(3'd3, 0, 0, 10);  // R10 word 1 unchanged by busy write
    mon_on = 1;
    pulse_start();
    end_run("R10 table");

    // R10: start with zero count
    set_count(32'd0);
    pulse_start();
    @(negedge clk);
    chk("R10 zero start busy", 64'(busy), 64'd0);
    chk("R10 zero start done", 64'(done), 64'd1);

    // R9: abort clears done in idle
    tick();
    abort = 1'b1;
    tick();
    abort = 1'b0;
    chk("R9 done cleared by abort", 64'(done), 64'd0);

    report();
  end
endmodule